// File: doc/BRIEF.md
# Direct-Page and Indexed Effective Address Generator

This block turns an addressing-mode request into the 24-bit memory address a processor core should drive. It covers direct-page references (unindexed, X-indexed, Y-indexed) under both the native and the 8-bit-compatible emulation regime. It covers the three pointer-byte fetches of a long-indirect reference and the final Y-indexed long-indirect target. It also covers absolute references built from a bank byte and a 16-bit operand, with or without an index. The address arithmetic is combinational. One registered output stage holds the result.

Requests enter on a valid/ready handshake and results leave on another. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its content is being taken in the same cycle, so back-pressure from `out_ready` stalls the input directly. While `out_valid` is high and `out_ready` is low, the held address does not change. Pointer-byte selection comes from an external cycle counter on `ptr_step`. Index width and memory access are the caller's concern: index values arrive already zero-extended to 16 bits.

Top module: `dp_ea_gen`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With `emu`=0, modes 0 (direct), 1 (direct,X) and 2 (direct,Y) give the address {8'h00, (dreg + operand[7:0] + index) mod 2^16}, where index is 0, `idx_x` or `idx_y` respectively.
- R3: With `emu`=1 and `dreg`=16'h0000, modes 0 to 2 give {16'h0000, (operand[7:0] + index[7:0]) mod 256}, so the address wraps inside the first 256 bytes.
- R4: With `emu`=1, `dreg[7:0]`=0 and `dreg[15:8]`≠0, modes 0 to 2 give {8'h00, dreg[15:8], (operand[7:0] + index[7:0]) mod 256}, so the address wraps inside that page.
- R5: With `emu`=1 and `dreg[7:0]`≠0, modes 0 to 2 follow the R2 formula with no page wrap.
- R6: Mode 3 (pointer fetch) gives {8'h00, (dreg + operand[7:0] + ptr_step) mod 2^16} in either regime. `ptr_step` 0, 1 and 2 select the low, high and bank pointer byte, and a fetch from offset FE or FF carries into the next page.
- R7: Mode 4 (long indirect, Y-indexed) gives (`ptr_val` + `idx_y`) mod 2^24, with carry into the bank byte.
- R8: Modes 5 (absolute,X), 6 (absolute,Y) and 7 (absolute) give ({`bank`, `operand`} + index) mod 2^24, where index is `idx_x`, `idx_y` or 0. Crossing the end of a bank moves into the next bank.
- R9: A request is accepted when `in_valid` and `in_ready` are both high, and its address appears on `out_addr` with `out_valid`=1 one clock later. `in_ready` = !`out_valid` | `out_ready`. While `out_valid`=1 and `out_ready`=0, `out_addr` holds steady and new requests are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| mode | input | 3 | Addressing mode code (see R2 to R8) |
| emu | input | 1 | 1 = emulation regime, 0 = native |
| dreg | input | 16 | Direct-page base register |
| operand | input | 16 | Instruction operand (direct modes use bits 7:0) |
| idx_x | input | 16 | X index, zero-extended |
| idx_y | input | 16 | Y index, zero-extended |
| bank | input | 8 | Bank byte for absolute modes |
| ptr_val | input | 24 | Fetched long pointer for mode 4 |
| ptr_step | input | 2 | Pointer byte selector for mode 3 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_addr | output | 24 | Effective address |

## Verification
The bench runs all three emulation cases and the native case at operand offsets FE and FF with indices that push the low byte past FF. A design that ignored the low byte of the direct register would wrap a page it should not. A design that always wrapped would leak into the neighbouring page when the low byte is zero. Pointer fetches start at FE and FF with the direct register's low byte zero, where a design that wrongly applied the page wrap would fold the bank byte back to offset 00. Absolute and long-indirect sums are driven across a bank end and across FFFFFF, which exposes a 16-bit adder that drops the carry. A stalled consumer is also modelled, to catch an output register that reloads under back-pressure.

// File: rtl/dp_ea_pkg.sv
package dp_ea_pkg;
  typedef enum logic [2:0] {
    AM_DIR    = 3'd0,
    AM_DIR_X  = 3'd1,
    AM_DIR_Y  = 3'd2,
    AM_PTR    = 3'd3,
    AM_PTR_Y  = 3'd4,
    AM_ABS_X  = 3'd5,
    AM_ABS_Y  = 3'd6,
    AM_ABS    = 3'd7
  } amode_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/dp_page_wrap.sv
// Direct-page sum with the emulation page-wrap rule applied.
module dp_page_wrap
  import dp_ea_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          emu,
  input  logic [DW-1:0] dreg,
  input  logic [BYTE_W-1:0] offs,
  input  logic [DW-1:0] index,
  output logic [DW-1:0] addr
);
  localparam int unsigned HI_W = DW - BYTE_W;

  logic [DW-1:0] full_sum;
  logic          page_lock;

  always_comb begin
    full_sum  = dreg + {{HI_W{1'b0}}, offs} + index;
    // Page lock only when the low base byte is zero in emulation.
    page_lock = emu && (dreg[BYTE_W-1:0] == '0);
    if (page_lock)
      addr = {dreg[DW-1:BYTE_W], full_sum[BYTE_W-1:0]};
    else
      addr = full_sum;
  end
endmodule

// File: rtl/dp_ptr_addr.sv
// Address of one pointer byte; always carries across pages.
module dp_ptr_addr
  import dp_ea_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 2
) (
  input  logic [DW-1:0]     dreg,
  input  logic [BYTE_W-1:0] offs,
  input  logic [SW-1:0]     step,
  output logic [DW-1:0]     addr
);
  localparam int unsigned HI_W = DW - BYTE_W;
  localparam int unsigned SP_W = DW - SW;

  always_comb begin
    addr = dreg + {{HI_W{1'b0}}, offs} + {{SP_W{1'b0}}, step};
  end
endmodule

// File: rtl/dp_long_add.sv
// Full-width base plus zero-extended index, carrying into the bank.
module dp_long_add #(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] index,
  output logic [AW-1:0] sum
);
  localparam int unsigned EXT_W = AW - DW;

  always_comb begin
    sum = base + {{EXT_W{1'b0}}, index};
  end
endmodule

// File: rtl/dp_ea_gen.sv
module dp_ea_gen
  import dp_ea_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    mode,
  input  logic          emu,
  input  logic [DW-1:0] dreg,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [BYTE_W-1:0] bank,
  input  logic [AW-1:0] ptr_val,
  input  logic [SW-1:0] ptr_step,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);
  localparam int unsigned EXT_W = AW - DW;

  amode_e        am;
  logic [DW-1:0] dir_index;
  logic [DW-1:0] abs_index;
  logic [DW-1:0] dir_addr;
  logic [DW-1:0] ptr_addr;
  logic [AW-1:0] longy_addr;
  logic [AW-1:0] abs_addr;
  logic [AW-1:0] next_addr;
  logic          take;

  assign am = amode_e'(mode);

  always_comb begin
    unique case (am)
      AM_DIR_X: dir_index = idx_x;
      AM_DIR_Y: dir_index = idx_y;
      default:  dir_index = '0;
    endcase
    unique case (am)
      AM_ABS_X: abs_index = idx_x;
      AM_ABS_Y: abs_index = idx_y;
      default:  abs_index = '0;
    endcase
  end

  dp_page_wrap #(.DW(DW)) u_wrap (
    .emu   (emu),
    .dreg  (dreg),
    .offs  (operand[BYTE_W-1:0]),
    .index (dir_index),
    .addr  (dir_addr)
  );

  dp_ptr_addr #(.DW(DW), .SW(SW)) u_ptr (
    .dreg  (dreg),
    .offs  (operand[BYTE_W-1:0]),
    .step  (ptr_step),
    .addr  (ptr_addr)
  );

  dp_long_add #(.AW(AW), .DW(DW)) u_longy (
    .base  (ptr_val),
    .index (idx_y),
    .sum   (longy_addr)
  );

  dp_long_add #(.AW(AW), .DW(DW)) u_abs (
    .base  ({bank, operand}),
    .index (abs_index),
    .sum   (abs_addr)
  );

  always_comb begin
    unique case (am)
      AM_DIR, AM_DIR_X, AM_DIR_Y: next_addr = {{EXT_W{1'b0}}, dir_addr};
      AM_PTR:                     next_addr = {{EXT_W{1'b0}}, ptr_addr};
      AM_PTR_Y:                   next_addr = longy_addr;
      default:                    next_addr = abs_addr;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_addr  <= next_addr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R1: leaving reset the output stage is empty.
  assert_empty_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);

  // R9: a stalled result stays put.
  assert_hold_when_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R2: direct and pointer-fetch addresses never leave bank zero.
  assert_bank_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (mode <= 3'd3)) |=> (out_addr[AW-1:DW] == '0));

  // R3: emulation with a zero base stays in the first 256 bytes.
  assert_zero_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && emu && (dreg == '0) && (mode <= 3'd2)) |=> (out_addr[AW-1:BYTE_W] == '0));

  // R4: emulation with a page-aligned base stays in that page.
  assert_page_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && emu && (dreg[BYTE_W-1:0] == '0) && (mode <= 3'd2))
      |=> (out_addr[DW-1:BYTE_W] == $past(dreg[DW-1:BYTE_W])));
endmodule

// File: tb/tb_dp_ea_gen.sv
module tb_dp_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  mode = '0;
  logic        emu = 1'b0;
  logic [15:0] dreg = '0;
  logic [15:0] operand = '0;
  logic [15:0] idx_x = '0;
  logic [15:0] idx_y = '0;
  logic [7:0]  bank = '0;
  logic [23:0] ptr_val = '0;
  logic [1:0]  ptr_step = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dp_ea_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .emu(emu), .dreg(dreg), .operand(operand),
    .idx_x(idx_x), .idx_y(idx_y), .bank(bank), .ptr_val(ptr_val),
    .ptr_step(ptr_step), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  // Drive one request, then sample the registered result.
  task automatic issue(input logic [2:0] m, input logic e, input logic [15:0] d,
                       input logic [15:0] op, input logic [15:0] x, input logic [15:0] y,
                       input logic [7:0] bk, input logic [23:0] pv, input logic [1:0] st,
                       input string req, input logic [23:0] exp);
    @(negedge clk);
    mode = m; emu = e; dreg = d; operand = op; idx_x = x; idx_y = y;
    bank = bk; ptr_val = pv; ptr_step = st; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {23'd0, out_valid}, 24'd1);
    check(req, out_addr, exp);
  endtask

  task automatic t_reset;
    check("R1 out_valid", {23'd0, out_valid}, 24'd0);
    check("R1 in_ready", {23'd0, in_ready}, 24'd1);
  endtask

  task automatic t_native;
    issue(3'd1, 1'b0, 16'h1234, 16'h00FE, 16'h0005, 16'h0, 8'h0, 24'h0, 2'd0, "R2 dir,x", 24'h001337);
    issue(3'd2, 1'b0, 16'hFFF0, 16'h00FF, 16'h0, 16'h0020, 8'h0, 24'h0, 2'd0, "R2 dir,y wrap16", 24'h00010F);
    issue(3'd0, 1'b0, 16'h0200, 16'h00FF, 16'h0, 16'h0, 8'h0, 24'h0, 2'd0, "R2 dir", 24'h0002FF);
  endtask

  task automatic t_emu_zero;
    issue(3'd1, 1'b1, 16'h0000, 16'h00FE, 16'h0005, 16'h0, 8'h0, 24'h0, 2'd0, "R3 FE,x", 24'h000003);
    issue(3'd2, 1'b1, 16'h0000, 16'h00FF, 16'h0, 16'h0001, 8'h0, 24'h0, 2'd0, "R3 FF,y", 24'h000000);
  endtask

  task automatic t_emu_page;
    issue(3'd1, 1'b1, 16'h1200, 16'h00FF, 16'h0003, 16'h0, 8'h0, 24'h0, 2'd0, "R4 FF,x", 24'h001202);
    issue(3'd2, 1'b1, 16'h1200, 16'h00FE, 16'h0, 16'h0003, 8'h0, 24'h0, 2'd0, "R4 FE,y", 24'h001201);
  endtask

  task automatic t_emu_unaligned;
    issue(3'd1, 1'b1, 16'h1234, 16'h00FE, 16'h0005, 16'h0, 8'h0, 24'h0, 2'd0, "R5 FE,x", 24'h001337);
    issue(3'd2, 1'b1, 16'h1234, 16'h00FF, 16'h0, 16'h0001, 8'h0, 24'h0, 2'd0, "R5 FF,y", 24'h001334);
  endtask

  task automatic t_ptr;
    issue(3'd3, 1'b1, 16'h0000, 16'h00FE, 16'h0, 16'h0, 8'h0, 24'h0, 2'd0, "R6 lo", 24'h0000FE);
    issue(3'd3, 1'b1, 16'h0000, 16'h00FE, 16'h0, 16'h0, 8'h0, 24'h0, 2'd1, "R6 hi", 24'h0000FF);
    issue(3'd3, 1'b1, 16'h0000, 16'h00FE, 16'h0, 16'h0, 8'h0, 24'h0, 2'd2, "R6 bank carry", 24'h000100);
    issue(3'd3, 1'b1, 16'h1200, 16'h00FF, 16'h0, 16'h0, 8'h0, 24'h0, 2'd1, "R6 page carry", 24'h001300);
    issue(3'd3, 1'b0, 16'hFFFF, 16'h00FF, 16'h0, 16'h0, 8'h0, 24'h0, 2'd2, "R6 native wrap", 24'h000100);
  endtask

  task automatic t_long_y;
    issue(3'd4, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0020, 8'h0, 24'h12FFF0, 2'd0, "R7 bank carry", 24'h130010);
    issue(3'd4, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0001, 8'h0, 24'hFFFFFF, 2'd0, "R7 top wrap", 24'h000000);
  endtask

  task automatic t_abs;
    issue(3'd5, 1'b0, 16'h0, 16'hFFF0, 16'h0020, 16'h0, 8'h12, 24'h0, 2'd0, "R8 abs,x", 24'h130010);
    issue(3'd6, 1'b1, 16'h0, 16'hFFFF, 16'h0, 16'h0001, 8'hFF, 24'h0, 2'd0, "R8 abs,y", 24'h000000);
    issue(3'd7, 1'b0, 16'h0, 16'h5678, 16'h0099, 16'h0077, 8'h34, 24'h0, 2'd0, "R8 abs", 24'h345678);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    mode = 3'd7; bank = 8'hAA; operand = 16'h0001; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R9 first", out_addr, 24'hAA0001);
    check("R9 in_ready low", {23'd0, in_ready}, 24'd0);
    operand = 16'h0002;
    @(negedge clk);
    check("R9 held", out_addr, 24'hAA0001);
    check("R9 still valid", {23'd0, out_valid}, 24'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second", out_addr, 24'hAA0002);
    @(negedge clk);
    check("R9 drained", {23'd0, out_valid}, 24'd0);
  endtask

  initial begin
    #200000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_native();
    t_emu_zero();
    t_emu_page();
    t_emu_unaligned();
    t_ptr();
    t_long_y();
    t_abs();
    t_backpressure();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule